// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block is the cycle-level controller that a small 16-bit CPU runs when it enters an exception. The possible causes are leaving reset, a non-maskable request (the X source), a maskable request (the I source), a software-interrupt strobe and an unimplemented-opcode trap strobe. Every entry starts with one shared vector-fetch cycle. In that cycle the block raises `vecFetch`, and an external priority unit places the vector address of the winning source on the bus. That address always lies in the top region of the map, 0xFFC0 to 0xFFFF, and the sequencer never forms it. The vector contents come back on `vecData` one cycle later. They are held in a register and are used first in cycle 3.

After the vector fetch the sequence takes one of three paths. On the reset path the block sets both mask bits, moves the stack pointer down by two and refills the instruction queue with three word fetches. On the hardware-interrupt path and on the software path it first pushes a return address and a set of register words at a falling stack pointer. It then updates the mask bits and refills the queue from the vector. These two paths differ only in which return address is saved. `resume` pulses for one cycle when normal execution may continue. A return-from-interrupt strobe reloads the mask bits, which is how a blocked maskable source is let through again.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst_n` is low, `vecFetch`, `wrReq`, `fetchReq` and `resume` are 0. In the same state `xMask` and `iMask` are 1 and `sp` equals `SP_INIT`.
- R2: Each exception entry has exactly one `vecFetch` cycle. That cycle is cycle 1, which is the first cycle after the clock edge that accepts the event. For reset, that edge is the first clock edge after `rst_n` rises.
- R3: `vecData` is captured in cycle 2 and `fetchReq` is never high in the cycle that follows `vecFetch`. The three refill fetches run on consecutive cycles, at the captured vector V, then V+2, then V+4.
- R4: On the reset path there are no word writes. In cycle 2 both masks are set and `sp` drops by 2, so `sp` reads SP_INIT-2 from cycle 3. Fetches run in cycles 3 to 5 and `resume` is high in cycle 6.
- R5: On the interrupt and software paths the block makes NREG+1 word writes, one per cycle, in cycles 2 to 2+NREG. Write k (k counted from 0) goes to address sp0-2(k+1). Write 0 carries the return address. Write k>0 carries `regWords[(k-1)*16 +: 16]`. Afterwards `sp` has dropped by 2(NREG+1).
- R6: For an X or I interrupt the saved return address is `curPc`. For a software interrupt or a trap it is `nextPc`. Both are sampled on the accepting edge.
- R7: On the interrupt and software paths the masks are updated in cycle 3+NREG and read their new values from cycle 4+NREG. `iMask` is always set. `xMask` is set only for an X interrupt and is otherwise left unchanged. Fetches run in cycles 4+NREG to 6+NREG and `resume` is high in cycle 7+NREG.
- R8: When several events are eligible in the same idle cycle, the fixed priority is X, then I, then software interrupt or trap. The losing events are not taken.
- R9: `xIrq` is ignored while `xMask` is 1 and `iIrq` is ignored while `iMask` is 1. Software-interrupt and trap strobes are taken whatever the masks hold.
- R10: Events that arrive while a sequence is running are dropped and do not start a later sequence.
- R11: When `rtiStrobe` is high in an idle cycle in which no event is accepted, `xMask` and `iMask` take `rtiX` and `rtiI` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; on release the reset path runs |
| xIrq | input | 1 | Non-maskable request level |
| iIrq | input | 1 | Maskable request level |
| swiStrobe | input | 1 | Software-interrupt instruction strobe |
| trapStrobe | input | 1 | Unimplemented-opcode trap strobe |
| curPc | input | 16 | Address of the instruction about to execute |
| nextPc | input | 16 | Address of the instruction after the current one |
| regWords | input | NREG*16 | Register words to push, word 0 in the low bits |
| vecData | input | 16 | Vector contents returned by the bus |
| rtiStrobe | input | 1 | Return-from-interrupt mask restore |
| rtiX | input | 1 | X mask value to restore |
| rtiI | input | 1 | I mask value to restore |
| vecFetch | output | 1 | Vector-fetch request to the priority unit |
| wrReq | output | 1 | Stack word write request |
| wrAddr | output | 16 | Stack write address |
| wrData | output | 16 | Stack write data |
| fetchReq | output | 1 | Program word fetch request |
| fetchAddr | output | 16 | Program fetch address |
| resume | output | 1 | One-cycle pulse: normal execution may resume |
| xMask | output | 1 | X mask bit |
| iMask | output | 1 | I mask bit |
| sp | output | 16 | Stack pointer |

## Verification
Cycle 1 is the cycle after the edge that accepts the event. Counted from there, `vecFetch` is due in cycle 1 and the reset-path fetches in cycles 3 to 5, with `resume` in cycle 6. The interrupt-path pushes are due in cycles 2 to 2+NREG, the mask change is visible from cycle 4+NREG and `resume` comes in cycle 7+NREG. The bench drives every input on a falling edge. It then samples each output on every later falling edge, noting the cycle number, and compares both the values and the cycle of each event against these counts. The vector stub places the real vector on `vecData` only in cycle 2 and a filler value at all other times, so a capture made in the wrong cycle shows up as a wrong fetch address.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int IDX_W = 4;

  typedef enum logic [1:0] {
    C_RST,
    C_XIRQ,
    C_IIRQ,
    C_SOFT
  } cause_e;

  typedef struct packed {
    logic             latchRet;
    logic             useNext;
    logic             capVec;
    logic             push;
    logic [IDX_W-1:0] pushIdx;
    logic             rstDec;
    logic             setI;
    logic             setX;
    logic             fetch;
    logic [1:0]       fetchIdx;
    logic             rtiLoad;
  } dpStb_t;

endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int NREG = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   xIrq,
  input  logic   iIrq,
  input  logic   swiStrobe,
  input  logic   trapStrobe,
  input  logic   rtiStrobe,
  input  logic   xMask,
  input  logic   iMask,
  output dpStb_t stb,
  output logic   vecFetch,
  output logic   resume
);

  localparam logic [IDX_W-1:0] LAST_PUSH  = IDX_W'(NREG);
  localparam logic [IDX_W-1:0] LAST_FETCH = IDX_W'(2);

  typedef enum logic [2:0] {
    S_START,
    S_IDLE,
    S_VEC,
    S_RMASK,
    S_PUSH,
    S_IMASK,
    S_FETCH,
    S_DONE
  } st_e;

  st_e              state, nxt;
  cause_e           cause, nxtCause;
  logic [IDX_W-1:0] cnt, nxtCnt;
  logic             takeX, takeI, takeS, anyEvt;

  // fixed priority: X, then I, then software / trap
  assign takeX  = xIrq && !xMask;
  assign takeI  = iIrq && !iMask && !takeX;
  assign takeS  = (swiStrobe || trapStrobe) && !takeX && !takeI;
  assign anyEvt = takeX || takeI || takeS;

  always_comb begin
    nxt      = state;
    nxtCause = cause;
    nxtCnt   = cnt;
    stb      = '0;
    vecFetch = 1'b0;
    resume   = 1'b0;
    case (state)
      S_START: begin
        nxt      = S_VEC;
        nxtCause = C_RST;
      end
      S_IDLE: begin
        if (anyEvt) begin
          nxt          = S_VEC;
          nxtCause     = takeX ? C_XIRQ : (takeI ? C_IIRQ : C_SOFT);
          stb.latchRet = 1'b1;
          stb.useNext  = takeS;
        end else begin
          stb.rtiLoad = rtiStrobe;
        end
      end
      S_VEC: begin
        vecFetch = 1'b1;
        nxtCnt   = '0;
        nxt      = (cause == C_RST) ? S_RMASK : S_PUSH;
      end
      S_RMASK: begin
        stb.capVec = 1'b1;
        stb.rstDec = 1'b1;
        stb.setI   = 1'b1;
        stb.setX   = 1'b1;
        nxtCnt     = '0;
        nxt        = S_FETCH;
      end
      S_PUSH: begin
        stb.capVec  = (cnt == '0);
        stb.push    = 1'b1;
        stb.pushIdx = cnt;
        if (cnt == LAST_PUSH) begin
          nxt = S_IMASK;
        end else begin
          nxtCnt = cnt + 1'b1;
        end
      end
      S_IMASK: begin
        stb.setI = 1'b1;
        stb.setX = (cause == C_XIRQ);
        nxtCnt   = '0;
        nxt      = S_FETCH;
      end
      S_FETCH: begin
        stb.fetch    = 1'b1;
        stb.fetchIdx = cnt[1:0];
        if (cnt == LAST_FETCH) begin
          nxt = S_DONE;
        end else begin
          nxtCnt = cnt + 1'b1;
        end
      end
      S_DONE: begin
        resume = 1'b1;
        nxt    = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_START;
      cause <= C_RST;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cause <= nxtCause;
      cnt   <= nxtCnt;
    end
  end

  // R4: the reset path never writes the stack
  a_r4_reset_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == C_RST && state != S_IDLE) |-> !stb.push);

  // R10: no event is accepted while a sequence is running
  a_r10_busy_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |-> !stb.latchRet);

endmodule

// File: rtl/exc_dpath.sv
module exc_dpath
  import exc_pkg::*;
#(
  parameter int          NREG    = 3,
  parameter logic [15:0] SP_INIT = 16'h2000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dpStb_t               stb,
  input  logic [15:0]          curPc,
  input  logic [15:0]          nextPc,
  input  logic [NREG*16-1:0]   regWords,
  input  logic [15:0]          vecData,
  input  logic                 rtiX,
  input  logic                 rtiI,
  output logic [15:0]          sp,
  output logic                 xMask,
  output logic                 iMask,
  output logic                 wrReq,
  output logic [15:0]          wrAddr,
  output logic [15:0]          wrData,
  output logic                 fetchReq,
  output logic [15:0]          fetchAddr
);

  localparam int NWORDS = NREG + 1;

  logic [15:0] retReg, vecReg, spDown;
  logic [15:0] pushWords [NWORDS];

  assign pushWords[0] = retReg;
  for (genvar k = 0; k < NREG; k++) begin : g_words
    assign pushWords[k+1] = regWords[k*16 +: 16];
  end

  assign spDown = sp - 16'd2;

  always_comb begin
    wrData = '0;
    for (int k = 0; k < NWORDS; k++) begin
      if (stb.pushIdx == IDX_W'(k)) wrData = pushWords[k];
    end
  end

  assign wrReq     = stb.push;
  assign wrAddr    = spDown;
  assign fetchReq  = stb.fetch;
  assign fetchAddr = vecReg + {13'd0, stb.fetchIdx, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp     <= SP_INIT;
      xMask  <= 1'b1;
      iMask  <= 1'b1;
      retReg <= '0;
      vecReg <= '0;
    end else begin
      if (stb.latchRet) retReg <= stb.useNext ? nextPc : curPc;
      if (stb.capVec) vecReg <= vecData;
      if (stb.push || stb.rstDec) sp <= spDown;
      if (stb.rtiLoad) begin
        xMask <= rtiX;
        iMask <= rtiI;
      end
      if (stb.setI) iMask <= 1'b1;
      if (stb.setX) xMask <= 1'b1;
    end
  end

  // R5: every stack write moves the stack pointer down one word
  a_r5_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    stb.push |=> (sp == $past(sp) - 16'd2));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int          NREG    = 3,
  parameter logic [15:0] SP_INIT = 16'h2000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xIrq,
  input  logic               iIrq,
  input  logic               swiStrobe,
  input  logic               trapStrobe,
  input  logic [15:0]        curPc,
  input  logic [15:0]        nextPc,
  input  logic [NREG*16-1:0] regWords,
  input  logic [15:0]        vecData,
  input  logic               rtiStrobe,
  input  logic               rtiX,
  input  logic               rtiI,
  output logic               vecFetch,
  output logic               wrReq,
  output logic [15:0]        wrAddr,
  output logic [15:0]        wrData,
  output logic               fetchReq,
  output logic [15:0]        fetchAddr,
  output logic               resume,
  output logic               xMask,
  output logic               iMask,
  output logic [15:0]        sp
);

  dpStb_t stb;

  exc_ctrl #(.NREG(NREG)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .xIrq       (xIrq),
    .iIrq       (iIrq),
    .swiStrobe  (swiStrobe),
    .trapStrobe (trapStrobe),
    .rtiStrobe  (rtiStrobe),
    .xMask      (xMask),
    .iMask      (iMask),
    .stb        (stb),
    .vecFetch   (vecFetch),
    .resume     (resume)
  );

  exc_dpath #(.NREG(NREG), .SP_INIT(SP_INIT)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .curPc     (curPc),
    .nextPc    (nextPc),
    .regWords  (regWords),
    .vecData   (vecData),
    .rtiX      (rtiX),
    .rtiI      (rtiI),
    .sp        (sp),
    .xMask     (xMask),
    .iMask     (iMask),
    .wrReq     (wrReq),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .fetchReq  (fetchReq),
    .fetchAddr (fetchAddr)
  );

  // R2: the vector fetch lasts exactly one cycle
  a_r2_single_vec: assert property (@(posedge clk) disable iff (!rst_n)
    vecFetch |=> !vecFetch);

  // R3: no program fetch right after the vector fetch
  a_r3_no_early_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    vecFetch |=> !fetchReq);

  // R7: execution resumes only with maskable requests blocked
  a_r7_resume_masked: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> iMask);

endmodule

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;

  localparam int          NREG    = 3;
  localparam logic [15:0] SP_INIT = 16'h2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xIrq = 1'b0, iIrq = 1'b0, swiStrobe = 1'b0, trapStrobe = 1'b0;
  logic [15:0] curPc = '0, nextPc = '0, vecData = 16'hDEAD;
  logic [NREG*16-1:0] regWords = {16'h3333, 16'h2222, 16'h1111};
  logic rtiStrobe = 1'b0, rtiX = 1'b0, rtiI = 1'b0;
  logic vecFetch, wrReq, fetchReq, resume, xMask, iMask;
  logic [15:0] wrAddr, wrData, fetchAddr, sp;

  always #10 clk = ~clk;

  exc_entry_seq #(.NREG(NREG), .SP_INIT(SP_INIT)) u0 (
    .clk(clk), .rst_n(rst_n), .xIrq(xIrq), .iIrq(iIrq),
    .swiStrobe(swiStrobe), .trapStrobe(trapStrobe),
    .curPc(curPc), .nextPc(nextPc), .regWords(regWords), .vecData(vecData),
    .rtiStrobe(rtiStrobe), .rtiX(rtiX), .rtiI(rtiI),
    .vecFetch(vecFetch), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .resume(resume),
    .xMask(xMask), .iMask(iMask), .sp(sp)
  );

  // vector stub: real contents only in the cycle after the request
  logic [15:0] vecVal = 16'h0000;
  logic prevVec = 1'b0;
  always @(negedge clk) begin
    prevVec <= vecFetch;
    vecData <= prevVec ? vecVal : 16'hDEAD;
  end

  int nChk = 0, nBad = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int vc, vcount, nW, nF, resC;
  logic [15:0] wa [8];
  logic [15:0] wd [8];
  int wc [8];
  logic [15:0] fa [4];
  int fc [4];
  logic imArr [20];
  logic xmArr [20];
  logic [15:0] spArr [20];

  task automatic capture(input int n, input int injAt);
    vc = 0; vcount = 0; nW = 0; nF = 0; resC = 0;
    for (int c = 1; c <= n; c++) begin
      @(negedge clk);
      if (c == 1) begin swiStrobe = 1'b0; trapStrobe = 1'b0; end
      if (vecFetch) begin vcount++; if (vc == 0) vc = c; end
      if (wrReq && nW < 8) begin wa[nW] = wrAddr; wd[nW] = wrData; wc[nW] = c; nW++; end
      if (fetchReq && nF < 4) begin fa[nF] = fetchAddr; fc[nF] = c; nF++; end
      if (resume && resC == 0) resC = c;
      if (c < 20) begin imArr[c] = iMask; xmArr[c] = xMask; spArr[c] = sp; end
      if (c == injAt) swiStrobe = 1'b1;
      else if (injAt > 0 && c == injAt + 1) swiStrobe = 1'b0;
    end
  endtask

  task automatic checkEntry(input string tag, input logic [15:0] sp0, input logic [15:0] ret,
                            input logic [15:0] vec, input logic expX, input logic oldI);
    logic [15:0] e;
    check({tag, " R2 vector fetch cycle"}, vc, 1);
    check({tag, " R2 vector fetch count"}, vcount, 1);
    check({tag, " R5 write count"}, nW, NREG + 1);
    for (int k = 0; k <= NREG; k++) begin
      e = sp0 - 16'(2 * (k + 1));
      check({tag, " R5 write address"}, wa[k], e);
      check({tag, " R5 write cycle"}, wc[k], 2 + k);
      if (k == 0) check({tag, " R6 return address"}, wd[0], ret);
      else check({tag, " R5 register word"}, wd[k], regWords[(k-1)*16 +: 16]);
    end
    check({tag, " R3 fetch count"}, nF, 3);
    for (int j = 0; j < 3; j++) begin
      check({tag, " R3 fetch address"}, fa[j], vec + 16'(2 * j));
      check({tag, " R7 fetch cycle"}, fc[j], 4 + NREG + j);
    end
    check({tag, " R7 I before update"}, imArr[3+NREG], oldI);
    check({tag, " R7 I set"}, imArr[4+NREG], 1'b1);
    check({tag, " R7 X result"}, xmArr[4+NREG], expX);
    check({tag, " R7 resume cycle"}, resC, 7 + NREG);
    check({tag, " R5 final sp"}, spArr[7+NREG], sp0 - 16'(2 * (NREG + 1)));
  endtask

  task automatic doRti(input logic nx, input logic ni);
    @(negedge clk);
    rtiStrobe = 1'b1; rtiX = nx; rtiI = ni;
    @(negedge clk);
    rtiStrobe = 1'b0;
    check("R11 X restored", xMask, nx);
    check("R11 I restored", iMask, ni);
  endtask

  task automatic testReset();
    @(negedge clk);
    @(negedge clk);
    check("R1 vecFetch in reset", vecFetch, 0);
    check("R1 wrReq in reset", wrReq, 0);
    check("R1 fetchReq in reset", fetchReq, 0);
    check("R1 resume in reset", resume, 0);
    check("R1 masks in reset", {xMask, iMask}, 2'b11);
    check("R1 sp in reset", sp, SP_INIT);
    vecVal = 16'hC000;
    rst_n = 1'b1;
    capture(8, 0);
    check("R2 reset vector cycle", vc, 1);
    check("R2 reset vector count", vcount, 1);
    check("R4 reset no writes", nW, 0);
    check("R4 sp before drop", spArr[2], SP_INIT);
    check("R4 sp after drop", spArr[3], SP_INIT - 16'd2);
    check("R4 masks set", {xmArr[3], imArr[3]}, 2'b11);
    check("R3 reset fetch count", nF, 3);
    for (int j = 0; j < 3; j++) begin
      check("R3 reset fetch address", fa[j], 16'hC000 + 16'(2 * j));
      check("R4 reset fetch cycle", fc[j], 3 + j);
    end
    check("R4 reset resume cycle", resC, 6);
  endtask

  task automatic testSwiMasked();
    @(negedge clk);
    curPc = 16'h3000; nextPc = 16'h3002; vecVal = 16'h8000;
    swiStrobe = 1'b1;
    capture(NREG + 9, 0);
    checkEntry("swi with masks set R9", 16'h1FFE, 16'h3002, 16'h8000, 1'b1, 1'b1);
  endtask

  task automatic testMaskedIgnored();
    @(negedge clk);
    xIrq = 1'b1; iIrq = 1'b1;
    capture(6, 0);
    check("R9 masked requests ignored", vcount, 0);
    xIrq = 1'b0; iIrq = 1'b0;
  endtask

  task automatic testIrqI();
    doRti(1'b0, 1'b0);
    curPc = 16'h4100; nextPc = 16'h4102; vecVal = 16'h8800;
    iIrq = 1'b1;
    capture(NREG + 9, 4);
    checkEntry("maskable irq R6", 16'h1FF6, 16'h4100, 16'h8800, 1'b0, 1'b0);
    capture(6, 0);
    check("R10 dropped swi and R9 blocked I", vcount, 0);
    iIrq = 1'b0;
  endtask

  task automatic testPriority();
    doRti(1'b0, 1'b0);
    curPc = 16'h5200; nextPc = 16'h5204; vecVal = 16'h9000;
    xIrq = 1'b1; iIrq = 1'b1; swiStrobe = 1'b1;
    capture(NREG + 9, 0);
    checkEntry("R8 X wins", 16'h1FEE, 16'h5200, 16'h9000, 1'b1, 1'b0);
    xIrq = 1'b0;
    doRti(1'b1, 1'b0);
    swiStrobe = 1'b1;
    curPc = 16'h6300; nextPc = 16'h6302; vecVal = 16'hA000;
    capture(NREG + 9, 0);
    checkEntry("R8 I beats swi", 16'h1FE6, 16'h6300, 16'hA000, 1'b1, 1'b0);
    iIrq = 1'b0;
  endtask

  task automatic testTrap();
    @(negedge clk);
    curPc = 16'h7000; nextPc = 16'h7004; vecVal = 16'hB000;
    trapStrobe = 1'b1;
    capture(NREG + 9, 0);
    checkEntry("trap R6", 16'h1FDE, 16'h7004, 16'hB000, 1'b1, 1'b1);
  endtask

  initial begin
    #(20 * 50000);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    testReset();
    testSwiMasked();
    testMaskedIgnored();
    testIrqI();
    testPriority();
    testTrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule